// File: doc/BRIEF.md
# SPI Slave Byte Engine with Phase-Dependent Framing

This block is the receive and transmit engine of an SPI target device. It moves one byte at a time, most significant bit first. It handles both clock polarities and both clock phases, chosen by two configuration inputs. SCK, MOSI and the active-low select are sampled into the system clock and turned into edge events there. The engine then shifts the transmit byte out on MISO and collects the bits that arrive on MOSI. When a byte is complete, the received value is placed on a holding output and a one-cycle done strobe fires.

How a byte begins depends on the phase setting:

- **Phase 0:** the fall of select opens the byte. The transmit byte is loaded at that moment, so the first bit is on MISO before the first clock edge. A further byte is accepted only after select has gone high and then low again.
- **Phase 1:** the first leading SCK edge opens the byte and loads the transmit byte. Select may stay low over any number of consecutive bytes.

In both phases, raising select in the middle of a byte throws away the bits collected so far.

Top module: `spis_slave`

## Requirements
- R1: Data is received MSB first, eight bits per byte, and the completed byte appears on rx_byte.
- R2: With cfg_cpha=0, tx_byte is loaded when select falls, so its MSB is on miso_out before the first SCK edge. Bits are captured on the leading edge and the next MISO bit is shifted out on the trailing edge.
- R3: The leading edge is the rising edge of SCK when cfg_cpol=0 (SCK idles low). It is the falling edge when cfg_cpol=1 (SCK idles high).
- R4: With cfg_cpha=0, SCK edges that arrive after a completed byte, while select has stayed low, are ignored: no rx_done pulse and no change to rx_byte.
- R5: With cfg_cpha=1, the first leading edge of each byte loads tx_byte and drives its MSB. Bits are captured on trailing edges. Consecutive bytes with select held low are each received and answered.
- R6: rx_done is high for exactly one system clock cycle for each completed byte.
- R7: miso_oe is low while select is high and high while select is low, allowing for the synchroniser delay.
- R8: A rise of select before the eighth capture discards the partial byte: no rx_done, rx_byte unchanged. The next byte is received whole.
- R9: After reset, rx_byte is 0, rx_done is 0 and miso_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level (0 low, 1 high) |
| cfg_cpha | input | 1 | Phase: 0 captures on leading edge, 1 on trailing edge |
| tx_byte | input | 8 | Byte to be sent on MISO |
| rx_byte | output | 8 | Last completed received byte |
| rx_done | output | 1 | One-cycle strobe when rx_byte updates |
| sck_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| ssn_in | input | 1 | Active-low slave select |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
The main function is exercised in all four polarity/phase combinations, each with its own data pair. This shows that leading and trailing edges are told apart for both idle levels and that each phase loads the transmit byte at the right moment. A phase-1 run with select held low over two bytes, with a different transmit byte for each, separates per-byte framing from per-select framing. The same held-select pattern in phase 0 must instead be ignored. Bytes cut short by select in either phase confirm that the bit counter restarts, because the byte that follows must still come through intact.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int unsigned SPIS_DATA_W = 8;
    localparam int unsigned SPIS_SYNC_N = 2;

    // Edge events seen in the system clock domain
    typedef struct packed {
        logic cap;          // sample MOSI
        logic shft;         // advance MISO
        logic frame_open;   // select has just fallen
    } spis_evt_t;

    // Choose the rising or falling event according to the idle level
    function automatic logic spis_pick(input logic cpol, input logic rise, input logic fall);
        return cpol ? fall : rise;
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
    import spis_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cpol,
    input  logic      cpha,
    input  logic      sck_s,
    input  logic      ssn_s,
    output spis_evt_t evt
);
    logic sck_q, ssn_q;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            ssn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ssn_q <= ssn_s;
        end
    end

    always_comb begin
        rise  = sck_s & ~sck_q;
        fall  = ~sck_s & sck_q;
        lead  = spis_pick(cpol, rise, fall);
        trail = spis_pick(cpol, fall, rise);
        evt.cap        = cpha ? trail : lead;
        evt.shft       = cpha ? lead  : trail;
        evt.frame_open = ~ssn_s & ssn_q;
    end
endmodule

// File: rtl/spis_shift.sv
module spis_shift
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W = SPIS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  spis_evt_t         evt,
    input  logic              mosi_s,
    input  logic              ssn_s,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr, rx_sr, rx_q, rx_next;
    logic [CNT_W-1:0]  cnt;
    logic              armed, oe_q, done_q, live;

    assign rx_next = {rx_sr[DATA_W-2:0], mosi_s};
    assign live    = cpha | armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            rx_sr  <= '0;
            rx_q   <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            oe_q   <= ~ssn_s;
            if (ssn_s) begin
                cnt   <= '0;
                armed <= 1'b0;
            end else if (!cpha && evt.frame_open) begin
                tx_sr <= tx_byte;
                cnt   <= '0;
                armed <= 1'b1;
            end else begin
                if (evt.cap && live) begin
                    rx_sr <= rx_next;
                    if (cnt == LAST) begin
                        cnt    <= '0;
                        rx_q   <= rx_next;
                        done_q <= 1'b1;
                        armed  <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (evt.shft && live) begin
                    if (cpha && cnt == '0) tx_sr <= tx_byte;
                    else                   tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso    = tx_sr[DATA_W-1];
    assign miso_oe = oe_q;
    assign rx_byte = rx_q;
    assign rx_done = done_q;

    // R7: output driver released once select is high
    assert_oe_released_R7: assert property (@(posedge clk) disable iff (rst)
        ssn_s |=> !miso_oe);
    // R6: strobe lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);
    // R6: strobe only follows a capture event
    assert_done_after_cap_R6: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $past(evt.cap));
    // R8: no byte completes while deselected
    assert_done_selected_R8: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $past(!ssn_s));
    // R4: in phase 0 a byte completes only inside an opened frame
    assert_cpha0_framed_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !cpha) |-> $past(armed));
    // R2: MISO moves only on a shift event or frame start
    assert_miso_moves_on_shift_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(miso) |-> $past(evt.shft || evt.frame_open));
endmodule

// File: rtl/spis_slave.sv
module spis_slave
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W = SPIS_DATA_W,
    parameter int unsigned SYNC_N = SPIS_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              ssn_in,
    output logic              miso_out,
    output logic              miso_oe
);
    logic [2:0] pins_s;
    spis_evt_t  evt;

    spis_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_in, mosi_in, ssn_in}),
        .q   (pins_s)
    );

    spis_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .cpol  (cfg_cpol),
        .cpha  (cfg_cpha),
        .sck_s (pins_s[2]),
        .ssn_s (pins_s[0]),
        .evt   (evt)
    );

    spis_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .cpha    (cfg_cpha),
        .evt     (evt),
        .mosi_s  (pins_s[1]),
        .ssn_s   (pins_s[0]),
        .tx_byte (tx_byte),
        .miso    (miso_out),
        .miso_oe (miso_oe),
        .rx_byte (rx_byte),
        .rx_done (rx_done)
    );
endmodule

// File: tb/spis_slave_tb_top.sv
module spis_slave_tb_top;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       rx_done;
    logic       sck_in = 1'b0, mosi_in = 1'b0, ssn_in = 1'b1;
    logic       miso_out, miso_oe;

    int n_chk = 0, n_bad = 0, done_cnt = 0, run = 0, max_run = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spis_slave dut_i (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_done(rx_done),
        .sck_in(sck_in), .mosi_in(mosi_in), .ssn_in(ssn_in),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    always @(negedge clk) begin
        if (rx_done) begin
            done_cnt++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Master side: clocks nb bits, returns what was seen on MISO
    task automatic spi_bits(input logic [7:0] mo, input int nb, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 0; i < nb; i++) begin
            if (!cfg_cpha) begin
                mi = {mi[6:0], miso_out};
                sck_in = ~cfg_cpol;
                wait_clk(H);
                if (i < 7) mosi_in = mo[6-i];
                sck_in = cfg_cpol;
                wait_clk(H);
            end else begin
                mosi_in = mo[7-i];
                sck_in = ~cfg_cpol;
                wait_clk(H);
                mi = {mi[6:0], miso_out};
                sck_in = cfg_cpol;
                wait_clk(H);
            end
        end
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        ssn_in = 1'b1;
        wait_clk(H);
        cfg_cpol = pol;
        cfg_cpha = pha;
        sck_in = pol;
        wait_clk(H);
    endtask

    task automatic open_sel(input logic [7:0] mo);
        mosi_in = mo[7];
        ssn_in = 1'b0;
        wait_clk(H);
    endtask

    task automatic close_sel();
        wait_clk(2);
        ssn_in = 1'b1;
        wait_clk(H);
    endtask

    task automatic t_reset();
        chk("R9 rx_byte", rx_byte, 0);
        chk("R9 rx_done", rx_done, 0);
        chk("R9 miso_oe", miso_oe, 0);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [7:0] mo,
                          input logic [7:0] tb, input string req);
        logic [7:0] mi;
        int d0;
        set_mode(pol, pha);
        chk("R7 oe off", miso_oe, 0);
        tx_byte = tb;
        d0 = done_cnt;
        open_sel(mo);
        chk("R7 oe on", miso_oe, 1);
        spi_bits(mo, 8, mi);
        wait_clk(4);
        chk({req, " R1 rx"}, rx_byte, mo);
        chk({req, " tx"}, mi, tb);
        chk("R6 one done", done_cnt - d0, 1);
        close_sel();
        chk("R7 oe off after", miso_oe, 0);
    endtask

    task automatic t_back_to_back();
        logic [7:0] mi;
        int d0;
        set_mode(1'b1, 1'b1);
        tx_byte = 8'h5A;
        d0 = done_cnt;
        open_sel(8'h81);
        spi_bits(8'h81, 8, mi);
        wait_clk(4);
        chk("R5 first rx", rx_byte, 8'h81);
        chk("R5 first tx", mi, 8'h5A);
        tx_byte = 8'hC3;
        spi_bits(8'h7E, 8, mi);
        wait_clk(4);
        chk("R5 second rx", rx_byte, 8'h7E);
        chk("R5 second tx", mi, 8'hC3);
        chk("R5 two done", done_cnt - d0, 2);
        close_sel();
    endtask

    task automatic t_no_toggle();
        logic [7:0] mi;
        int d0;
        set_mode(1'b0, 1'b0);
        tx_byte = 8'h11;
        d0 = done_cnt;
        open_sel(8'h96);
        spi_bits(8'h96, 8, mi);
        mosi_in = 1'b0;
        spi_bits(8'h69, 8, mi);
        wait_clk(4);
        chk("R4 rx kept", rx_byte, 8'h96);
        chk("R4 one done", done_cnt - d0, 1);
        close_sel();
    endtask

    task automatic t_abort(input logic pha, input logic [7:0] full, input logic [7:0] keep);
        logic [7:0] mi;
        int d0;
        set_mode(1'b0, pha);
        tx_byte = 8'hA0;
        d0 = done_cnt;
        open_sel(8'hF0);
        spi_bits(8'hF0, 4, mi);
        close_sel();
        chk("R8 no done", done_cnt - d0, 0);
        chk("R8 rx kept", rx_byte, keep);
        open_sel(full);
        spi_bits(full, 8, mi);
        wait_clk(4);
        chk("R8 next byte", rx_byte, full);
        chk("R8 next tx", mi, 8'hA0);
        close_sel();
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_mode(1'b0, 1'b0, 8'hA5, 8'h3C, "R2 mode0");
        t_mode(1'b1, 1'b0, 8'h4B, 8'hE1, "R3 mode2");
        t_mode(1'b0, 1'b1, 8'h37, 8'h9C, "R5 mode1");
        t_mode(1'b1, 1'b1, 8'hD2, 8'h06, "R3 mode3");
        t_back_to_back();
        t_no_toggle();
        t_abort(1'b0, 8'h2D, 8'h96);
        t_abort(1'b1, 8'hB4, 8'h2D);
        chk("R6 pulse width", max_run, 1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule